// File: doc/BRIEF.md
# Interconnect Agent Error Status Unit

This block holds the error state of a single interconnect agent port. In-band error pulses from the fabric set sticky flags. For an initiator-side port there is an application (primary) flag and a debug (secondary) flag. For a target-side port there is one flag, raised when the target answers with an error. Software clears these flags with write-one-to-clear accesses.

The block also watches the one transaction the agent may have outstanding. A request is taken over a valid/ready handshake, and a programmable down-counter then waits for the completion pulse. If the counter runs out first, a time-out flag is set. No status write can acknowledge this flag. While it is set, every new request is accepted at once and answered with an error. The only way back is the agent-reset bit in the control register, which wipes all error state.

An interrupt line reports any status bit that is set and enabled in the mask register.

Top module: `agent_err_unit`

## Requirements
- R1: After reset, status (address 0) reads 0, control (address 1) reads 0, mask (address 2) reads 0, limit (address 3) reads DEF_LIMIT, `irq` is 0, `req_ready` is 1 and `req_err` is 0.
- R2: In the default initiator variant, a one-cycle pulse on `err_evt_i[0]` sets status bit 28 and a pulse on `err_evt_i[1]` sets status bit 29. Each bit shows in the cycle after the pulse and stays set with no further pulse. In the target variant, `err_evt_i[0]` sets bit 24.
- R3: A write to address 0 clears each event bit whose write-data bit is 1. Bits written 0 keep their value.
- R4: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends set.
- R5: A request is taken when `req_valid` and `req_ready` are both high. After an accepted request, `req_ready` stays low until a `cpl_valid` pulse arrives.
- R6: Accepting a request loads the limit value L (low LIMIT_W bits of address 3). If `cpl_valid` is high in any of the first L+1 cycles after acceptance, the transaction ends cleanly. Otherwise status bit 16 (time-out) is set in cycle L+1 and the transaction is abandoned.
- R7: No write to address 0 clears status bit 16.
- R8: While bit 16 is set, `req_ready` is 1 and `req_err` is 1. Any request is accepted and rejected, and no transaction is started.
- R9: A write to address 1 with bit 0 set clears every status bit, including bit 16, and abandons any outstanding transaction. If an event arrives in that same cycle, the reset wins. Mask and limit keep their values, and address 1 always reads 0.
- R10: `irq` is 1 exactly when some status bit is set and the same bit of the mask register is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt_i | input | EVT_W | In-band error pulses (2 for initiator, 1 for target) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_err | output | 1 | Taken request is rejected with an error response |
| cpl_valid | input | 1 | Outstanding transaction completed |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 control, 2 mask, 3 limit) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Masked error interrupt |

## Verification
Event flags, clears, agent reset, mask and limit updates all land on the first rising edge after the stimulus. They are readable one cycle later, and reads and `irq` follow combinationally from registers. The time-out path is the one multi-cycle result. Counting from the accepting edge, the flag must still be clear after L edges and set after edge L+1. A completion given just before that edge must win. The bench drives every input on the falling edge and samples on the next falling edge, or after the exact number of falling edges for the time-out, so each check lands in the cycle the requirement names.

// File: rtl/agent_err_pkg.sv
package agent_err_pkg;
  localparam int REG_W        = 32;
  localparam int TO_BIT       = 16;
  localparam int CTRL_RST_BIT = 0;

  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_CTRL   = 2'd1,
    ADDR_MASK   = 2'd2,
    ADDR_LIMIT  = 2'd3
  } reg_addr_e;

  // Status bit position of event input idx for the chosen agent side.
  function automatic int evt_bit(input bit is_target, input int idx);
    return is_target ? 24 : 28 + idx;
  endfunction
endpackage

// File: rtl/agent_err_sticky.sv
module agent_err_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q_o <= 1'b0;
    else if (soft_rst) q_o <= 1'b0;
    else if (set_i)    q_o <= 1'b1;   // a new event beats a clear
    else if (clr_i)    q_o <= 1'b0;
  end
endmodule

// File: rtl/agent_err_timer.sv
module agent_err_timer #(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               start_i,
  input  logic               cpl_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               busy_o,
  output logic               to_o
);
  logic [LIMIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
      to_o   <= 1'b0;
    end else if (soft_rst) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
      to_o   <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= limit_i;
      busy_o <= 1'b1;
    end else if (busy_o) begin
      if (cpl_i) begin
        busy_o <= 1'b0;
      end else if (cnt_q == '0) begin
        busy_o <= 1'b0;
        to_o   <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/agent_err_unit.sv
module agent_err_unit
  import agent_err_pkg::*;
#(
  parameter bit  IS_TARGET = 1'b0,
  parameter int  LIMIT_W   = 16,
  parameter int  DEF_LIMIT = 8,
  localparam int EVT_W     = IS_TARGET ? 1 : 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] err_evt_i,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             req_err,
  input  logic             cpl_valid,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq
);
  logic wr_stat, wr_ctrl, wr_mask, wr_lim, soft_rst;
  logic busy, to_flag, start;
  logic [EVT_W-1:0]   evt_q;
  logic [REG_W-1:0]   stat_vec, mask_q;
  logic [LIMIT_W-1:0] limit_q;

  assign wr_stat  = reg_wr && (reg_addr == ADDR_STATUS);
  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_mask  = reg_wr && (reg_addr == ADDR_MASK);
  assign wr_lim   = reg_wr && (reg_addr == ADDR_LIMIT);
  assign soft_rst = wr_ctrl && reg_wdata[CTRL_RST_BIT];

  for (genvar i = 0; i < EVT_W; i++) begin : g_flag
    localparam int POS = evt_bit(IS_TARGET, i);
    agent_err_sticky u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .set_i    (err_evt_i[i]),
      .clr_i    (wr_stat && reg_wdata[POS]),
      .q_o      (evt_q[i])
    );
  end

  assign req_ready = !busy;
  assign req_err   = to_flag;
  assign start     = req_valid && req_ready && !to_flag;

  agent_err_timer #(.LIMIT_W(LIMIT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .start_i  (start),
    .cpl_i    (cpl_valid),
    .limit_i  (limit_q),
    .busy_o   (busy),
    .to_o     (to_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      limit_q <= LIMIT_W'(DEF_LIMIT);
    end else begin
      if (wr_mask) mask_q  <= reg_wdata;
      if (wr_lim)  limit_q <= reg_wdata[LIMIT_W-1:0];
    end
  end

  always_comb begin
    stat_vec = '0;
    for (int i = 0; i < EVT_W; i++) stat_vec[evt_bit(IS_TARGET, i)] = evt_q[i];
    stat_vec[TO_BIT] = to_flag;
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_STATUS: reg_rdata = stat_vec;
      ADDR_MASK:   reg_rdata = mask_q;
      ADDR_LIMIT:  reg_rdata = {{(REG_W-LIMIT_W){1'b0}}, limit_q};
      default:     reg_rdata = '0;
    endcase
  end

  assign irq = |(stat_vec & mask_q);
endmodule

// File: rtl/agent_err_checker.sv
module agent_err_checker
  import agent_err_pkg::*;
#(
  parameter bit  IS_TARGET = 1'b0,
  localparam int EVT_W     = IS_TARGET ? 1 : 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [EVT_W-1:0] err_evt_i,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] stat_vec,
  input logic             busy,
  input logic             req_ready,
  input logic             req_err
);
  localparam int P0 = evt_bit(IS_TARGET, 0);
  logic agent_rst;
  assign agent_rst = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[CTRL_RST_BIT];

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt_i[0] && !agent_rst |=> stat_vec[P0]); // R2
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt_i[0] && reg_wr && (reg_addr == ADDR_STATUS) && reg_wdata[P0] |=> stat_vec[P0]); // R4
  AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R5
  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vec[TO_BIT] && !agent_rst |=> stat_vec[TO_BIT]); // R7
  AST_TIMEOUT_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vec[TO_BIT] |-> req_ready && req_err && !busy); // R8
  AST_AGENT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    agent_rst |=> stat_vec == '0 && !busy); // R9
endmodule

bind agent_err_unit agent_err_checker #(.IS_TARGET(IS_TARGET)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .err_evt_i (err_evt_i),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .stat_vec  (stat_vec),
  .busy      (busy),
  .req_ready (req_ready),
  .req_err   (req_err)
);

// File: tb/agent_err_unit_bench.sv
module agent_err_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] B_PRI = 32'h1000_0000;
  localparam logic [31:0] B_SEC = 32'h2000_0000;
  localparam logic [31:0] B_TO  = 32'h0001_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  err_evt_i = '0;
  logic        req_valid = 1'b0, cpl_valid = 1'b0, reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        req_ready, req_err, irq;
  logic [31:0] reg_rdata;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  agent_err_unit u_agent_err_unit (
    .clk(clk), .rst_n(rst_n), .err_evt_i(err_evt_i), .req_valid(req_valid),
    .req_ready(req_ready), .req_err(req_err), .cpl_valid(cpl_valid),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulse(input int idx);
    err_evt_i[idx] = 1'b1; @(negedge clk); err_evt_i = '0;
  endtask

  task automatic accept_req();
    req_valid = 1'b1; @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d); check("R1 status", d, 0);
    rd(1, d); check("R1 control", d, 0);
    rd(2, d); check("R1 mask", d, 0);
    rd(3, d); check("R1 limit", d, 8);
    check("R1 irq", irq, 0);
    check("R1 ready", req_ready, 1);
    check("R1 req_err", req_err, 0);
  endtask

  task automatic t_capture();
    logic [31:0] d;
    pulse(0); rd(0, d); check("R2 primary", d, B_PRI);
    pulse(1); rd(0, d); check("R2 secondary", d, B_PRI | B_SEC);
    repeat (3) @(negedge clk);
    rd(0, d); check("R2 sticky", d, B_PRI | B_SEC);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(0, B_PRI); rd(0, d); check("R3 clear primary only", d, B_SEC);
    wr(0, 32'h0); rd(0, d); check("R3 zero write keeps", d, B_SEC);
    wr(0, B_SEC); rd(0, d); check("R3 clear secondary", d, 0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    err_evt_i[0] = 1'b1;
    wr(0, B_PRI);
    err_evt_i = '0;
    rd(0, d); check("R4 set wins", d, B_PRI);
    wr(0, B_PRI); rd(0, d); check("R4 later clear", d, 0);
  endtask

  task automatic t_irq();
    pulse(1);
    check("R10 masked off", irq, 0);
    wr(2, B_SEC); check("R10 enabled", irq, 1);
    wr(2, B_PRI); check("R10 other bit enabled", irq, 0);
    wr(0, B_SEC); wr(2, 32'h0);
  endtask

  task automatic t_complete();
    logic [31:0] d;
    wr(3, 32'd3);
    accept_req();
    check("R5 busy stalls", req_ready, 0);
    repeat (3) @(negedge clk);
    check("R5 still busy", req_ready, 0);
    cpl_valid = 1'b1; @(negedge clk); cpl_valid = 1'b0;
    check("R5 ready after completion", req_ready, 1);
    rd(0, d); check("R6 completion in time", d, 0);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    accept_req();
    repeat (3) @(negedge clk);
    rd(0, d); check("R6 not yet timed out", d, 0);
    @(negedge clk);
    rd(0, d); check("R6 timed out at L+1", d, B_TO);
    check("R8 reject error", req_err, 1);
    check("R8 ready", req_ready, 1);
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); check("R7 no acknowledge", d, B_TO);
    accept_req();
    check("R8 nothing started", req_ready, 1);
    wr(2, B_TO); check("R10 timeout irq", irq, 1);
  endtask

  task automatic t_agent_reset();
    logic [31:0] d;
    pulse(0);
    err_evt_i[1] = 1'b1;
    wr(1, 32'h1);
    err_evt_i = '0;
    rd(0, d); check("R9 all cleared", d, 0);
    check("R9 req_err low", req_err, 0);
    check("R9 irq low", irq, 0);
    rd(3, d); check("R9 limit kept", d, 3);
    rd(2, d); check("R9 mask kept", d, B_TO);
    rd(1, d); check("R9 control reads 0", d, 0);
    accept_req();
    check("R9 normal after reset", req_ready, 0);
    cpl_valid = 1'b1; @(negedge clk); cpl_valid = 1'b0;
    check("R9 completion after reset", req_ready, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_capture();
    t_clear();
    t_race();
    t_irq();
    t_complete();
    t_timeout();
    t_agent_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule